// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a small four-register, 16-bit processor that executes each instruction over several clock cycles. It reads the opcode and the two register fields of the byte held in the instruction register, together with the registered zero flag. From these it drives every datapath control line: the register load strobes, the program counter load and increment, the two bus source select codes and the memory write strobe.

Every instruction begins with the same two fetch cycles and a decode cycle. The block then runs a short execute sequence and returns to the first fetch state. ALU operations take one execute cycle. Memory reads and writes, and branches, use the memory word that follows the instruction byte as an address or target. A conditional branch that is not taken skips that word by incrementing the program counter. A halt instruction parks the machine until reset.

The outputs depend only on the state and the instruction fields. The one exception is the zero flag, which matters in the decode cycle of a conditional branch. The datapath, the memory and the instruction register are outside this block.

Top module: `seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `state` is 0 (idle) and every strobe and select output is 0. On the first rising clock edge after release, `state` becomes 1.
- R2: In state 1, `bus1_sel`=4 (program counter), `bus2_sel`=1 (bus 1 passed through) and `ld_addr` are driven. State 2 follows with `bus2_sel`=2 (memory), `ld_ir` and `inc_pc`, and then the decode state 3. Bus 1 select codes are 0 to 3 for R0 to R3 and 4 for the program counter. Bus 2 select codes are 0 for the ALU, 1 for bus 1 and 2 for memory. Any select code or strobe that a cycle does not use is 0.
- R3: In the instruction byte, bits [7:4] are the opcode, [3:2] the source register and [1:0] the destination register. For the ALU opcodes 0001, 0010, 0011, 0100, 1001, 1010, 1011 and 1100, state 3 drives `bus1_sel`=source and `ld_y`. State 4 then drives `bus1_sel`=destination, `bus2_sel`=0, `ld_reg` bit [destination] and `ld_z`, and the machine returns to state 1.
- R4: Opcode 0000 and the unused opcodes 1101 and 1110 drive no strobe in state 3 and return to state 1.
- R5: Opcode 0101 (read) loads the address register from the program counter in state 3. State 5 then loads it from memory with `inc_pc`, and state 6 loads the destination register from memory before the return to state 1.
- R6: Opcode 0110 (write) uses the same state 3 as a read. State 7 then fetches the address word with `inc_pc`, and state 8 drives `bus1_sel`=source with `mem_wr` for exactly one cycle before the return to state 1.
- R7: Opcode 0111 (branch) loads the address register from the program counter in state 3. State 9 then loads it from memory, and state 10 loads the program counter from memory with `ld_pc` before the return to state 1.
- R8: Opcode 1000 (branch if zero) follows the R7 sequence when `zero_flag` is 1. When `zero_flag` is 0, state 3 drives only `inc_pc` and the machine returns to state 1.
- R9: Opcode 1111 moves to state 11, where the machine stays with every strobe at 0 until reset.
- R10: At most one `ld_reg` bit is high at a time, and `ld_pc` and `inc_pc` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 8 | Instruction register contents |
| zero_flag | input | 1 | Registered ALU zero flag |
| ld_reg | output | 4 | Load strobes for R0..R3 |
| ld_pc | output | 1 | Load program counter from bus 2 |
| inc_pc | output | 1 | Increment program counter |
| ld_ir | output | 1 | Load instruction register from bus 2 |
| ld_addr | output | 1 | Load memory address register from bus 2 |
| ld_y | output | 1 | Load ALU operand register from bus 2 |
| ld_z | output | 1 | Capture ALU zero flag |
| bus1_sel | output | 3 | Bus 1 source select |
| bus2_sel | output | 2 | Bus 2 source select |
| mem_wr | output | 1 | Memory write strobe |
| state | output | 4 | Current state code |

## Verification
Two functions fall in the same cycle here. The first is the address-word fetch of a read or write, where the program counter increment and the address register load are asserted together. The second is the decode of a conditional branch, where the zero flag chooses between a skip increment and the branch path. The bench sweeps all sixteen opcodes with every source and destination pair under both values of the zero flag. For each case it compares the full output vector, state code included, cycle by cycle against a trace built from the requirements. A merged or misplaced strobe therefore shows up in the exact cycle where it occurs.

// File: rtl/seq_ctrl.sv
module seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] instr,
  input  logic       zero_flag,
  output logic [3:0] ld_reg,
  output logic       ld_pc,
  output logic       inc_pc,
  output logic       ld_ir,
  output logic       ld_addr,
  output logic       ld_y,
  output logic       ld_z,
  output logic [2:0] bus1_sel,
  output logic [1:0] bus2_sel,
  output logic       mem_wr,
  output logic [3:0] state
);
  localparam logic [3:0] ST_IDLE = 4'd0,  ST_FET1 = 4'd1,  ST_FET2 = 4'd2,
                         ST_DEC  = 4'd3,  ST_EX1  = 4'd4,  ST_RD1  = 4'd5,
                         ST_RD2  = 4'd6,  ST_WR1  = 4'd7,  ST_WR2  = 4'd8,
                         ST_BR1  = 4'd9,  ST_BR2  = 4'd10, ST_HALT = 4'd11;
  localparam logic [2:0] B1_PC = 3'd4;
  localparam logic [1:0] B2_ALU = 2'd0, B2_BUS1 = 2'd1, B2_MEM = 2'd2;

  logic [3:0] cur, nxt;
  wire  [3:0] op  = instr[7:4];
  wire  [1:0] src = instr[3:2];
  wire  [1:0] dst = instr[1:0];

  wire is_alu  = (op inside {4'b0001, 4'b0010, 4'b0011, 4'b0100,
                             4'b1001, 4'b1010, 4'b1011, 4'b1100});
  wire is_rd   = (op == 4'b0101);
  wire is_wr   = (op == 4'b0110);
  wire is_br   = (op == 4'b0111);
  wire is_brz  = (op == 4'b1000);
  wire is_halt = (op == 4'b1111);
  wire take_br = is_br || (is_brz && zero_flag);

  assign state = cur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cur <= ST_IDLE;
    else        cur <= nxt;

  always_comb begin
    nxt = ST_IDLE;
    case (cur)
      ST_IDLE: nxt = ST_FET1;
      ST_FET1: nxt = ST_FET2;
      ST_FET2: nxt = ST_DEC;
      ST_DEC: begin
        if      (is_alu)      nxt = ST_EX1;
        else if (is_rd)       nxt = ST_RD1;
        else if (is_wr)       nxt = ST_WR1;
        else if (take_br)     nxt = ST_BR1;
        else if (is_halt)     nxt = ST_HALT;
        else                  nxt = ST_FET1;
      end
      ST_EX1:  nxt = ST_FET1;
      ST_RD1:  nxt = ST_RD2;
      ST_RD2:  nxt = ST_FET1;
      ST_WR1:  nxt = ST_WR2;
      ST_WR2:  nxt = ST_FET1;
      ST_BR1:  nxt = ST_BR2;
      ST_BR2:  nxt = ST_FET1;
      ST_HALT: nxt = ST_HALT;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ld_reg   = '0;
    ld_pc    = 1'b0;
    inc_pc   = 1'b0;
    ld_ir    = 1'b0;
    ld_addr  = 1'b0;
    ld_y     = 1'b0;
    ld_z     = 1'b0;
    mem_wr   = 1'b0;
    bus1_sel = '0;
    bus2_sel = '0;
    case (cur)
      ST_FET1: begin
        bus1_sel = B1_PC;
        bus2_sel = B2_BUS1;
        ld_addr  = 1'b1;
      end
      ST_FET2: begin
        bus2_sel = B2_MEM;
        ld_ir    = 1'b1;
        inc_pc   = 1'b1;
      end
      ST_DEC: begin
        if (is_alu) begin
          bus1_sel = {1'b0, src};
          ld_y     = 1'b1;
        end else if (is_rd || is_wr || take_br) begin
          bus1_sel = B1_PC;
          bus2_sel = B2_BUS1;
          ld_addr  = 1'b1;
        end else if (is_brz) begin
          inc_pc   = 1'b1;
        end
      end
      ST_EX1: begin
        bus1_sel    = {1'b0, dst};
        bus2_sel    = B2_ALU;
        ld_reg[dst] = 1'b1;
        ld_z        = 1'b1;
      end
      ST_RD1, ST_WR1: begin
        bus2_sel = B2_MEM;
        ld_addr  = 1'b1;
        inc_pc   = 1'b1;
      end
      ST_RD2: begin
        bus2_sel    = B2_MEM;
        ld_reg[dst] = 1'b1;
      end
      ST_WR2: begin
        bus1_sel = {1'b0, src};
        mem_wr   = 1'b1;
      end
      ST_BR1: begin
        bus2_sel = B2_MEM;
        ld_addr  = 1'b1;
      end
      ST_BR2: begin
        bus2_sel = B2_MEM;
        ld_pc    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] instr,
  input logic       zero_flag,
  input logic [3:0] ld_reg,
  input logic       ld_pc,
  input logic       inc_pc,
  input logic       ld_ir,
  input logic       ld_addr,
  input logic       ld_y,
  input logic       ld_z,
  input logic       mem_wr,
  input logic [3:0] state
);
  // R1
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd0 |=> state == 4'd1);
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd1 |=> state == 4'd2);
  // R2
  decode_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd2 |=> state == 4'd3);
  // R6
  write_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  // R7
  branch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd10 |=> state == 4'd1);
  // R8
  skip_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd3 && instr[7:4] == 4'b1000 && !zero_flag) |=> state == 4'd1);
  // R9
  halt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == 4'd11 |=> state == 4'd11 &&
      !(|ld_reg || ld_pc || inc_pc || ld_ir || ld_addr || ld_y || ld_z || mem_wr));
  // R10
  one_reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_reg));
  // R10
  pc_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_pc && inc_pc));
endmodule

bind seq_ctrl seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .zero_flag(zero_flag),
  .ld_reg(ld_reg), .ld_pc(ld_pc), .inc_pc(inc_pc), .ld_ir(ld_ir),
  .ld_addr(ld_addr), .ld_y(ld_y), .ld_z(ld_z), .mem_wr(mem_wr),
  .state(state)
);

// File: tb/sim_seq_ctrl.sv
module sim_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] instr = '0;
  logic       zero_flag = 1'b0;
  logic [3:0] ld_reg;
  logic       ld_pc, inc_pc, ld_ir, ld_addr, ld_y, ld_z, mem_wr;
  logic [2:0] bus1_sel;
  logic [1:0] bus2_sel;
  logic [3:0] state;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .instr(instr), .zero_flag(zero_flag),
    .ld_reg(ld_reg), .ld_pc(ld_pc), .inc_pc(inc_pc), .ld_ir(ld_ir),
    .ld_addr(ld_addr), .ld_y(ld_y), .ld_z(ld_z), .bus1_sel(bus1_sel),
    .bus2_sel(bus2_sel), .mem_wr(mem_wr), .state(state)
  );

  function automatic logic [19:0] pk(int st, logic [3:0] lr, bit pc, bit inc,
      bit ir, bit ad, bit y, bit z, bit we, int b1, int b2);
    return {st[3:0], lr, pc, inc, ir, ad, y, z, we, b1[2:0], b2[1:0]};
  endfunction

  wire [19:0] got = {state, ld_reg, ld_pc, inc_pc, ld_ir, ld_addr, ld_y,
                     ld_z, mem_wr, bus1_sel, bus2_sel};

  logic [19:0] tr [0:7];
  int          tn;
  string       tag;

  task automatic build(int op, int src, int dst, bit z);
    logic [19:0] f1, idle, dadr;
    idle = pk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    f1   = pk(1, 0, 0, 0, 0, 1, 0, 0, 0, 4, 1);
    dadr = pk(3, 0, 0, 0, 0, 1, 0, 0, 0, 4, 1);
    tr[0] = idle;
    tr[1] = f1;
    tr[2] = pk(2, 0, 0, 1, 1, 0, 0, 0, 0, 0, 2);
    if (op inside {1, 2, 3, 4, 9, 10, 11, 12}) begin
      tag = "R3";
      tr[3] = pk(3, 0, 0, 0, 0, 0, 1, 0, 0, src, 0);
      tr[4] = pk(4, 4'(1 << dst), 0, 0, 0, 0, 0, 1, 0, dst, 0);
      tr[5] = f1; tn = 6;
    end else if (op == 5) begin
      tag = "R5";
      tr[3] = dadr;
      tr[4] = pk(5, 0, 0, 1, 0, 1, 0, 0, 0, 0, 2);
      tr[5] = pk(6, 4'(1 << dst), 0, 0, 0, 0, 0, 0, 0, 0, 2);
      tr[6] = f1; tn = 7;
    end else if (op == 6) begin
      tag = "R6";
      tr[3] = dadr;
      tr[4] = pk(7, 0, 0, 1, 0, 1, 0, 0, 0, 0, 2);
      tr[5] = pk(8, 0, 0, 0, 0, 0, 0, 0, 1, src, 0);
      tr[6] = f1; tn = 7;
    end else if (op == 7 || (op == 8 && z)) begin
      tag = (op == 7) ? "R7" : "R8";
      tr[3] = dadr;
      tr[4] = pk(9, 0, 0, 0, 0, 1, 0, 0, 0, 0, 2);
      tr[5] = pk(10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2);
      tr[6] = f1; tn = 7;
    end else if (op == 8) begin
      tag = "R8";
      tr[3] = pk(3, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      tr[4] = f1; tn = 5;
    end else if (op == 15) begin
      tag = "R9";
      tr[3] = pk(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int k = 4; k < 8; k++) tr[k] = pk(11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      tn = 8;
    end else begin
      tag = "R4";
      tr[3] = pk(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      tr[4] = f1; tn = 5;
    end
  endtask

  task automatic chk(logic [19:0] exp, string req, int op, int step);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d step=%0d actual=%h expected=%h", req, op, step, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int op = 0; op < 16; op++)
      for (int sd = 0; sd < 16; sd++)
        for (int z = 0; z < 2; z++) begin
          @(negedge clk);
          rst_n = 1'b0;
          instr = {4'(op), 4'(sd)};
          zero_flag = z[0];
          build(op, sd >> 2, sd & 3, z[0]);
          #1;
          // R1 reset state
          chk(tr[0], "R1", op, -1);
          @(negedge clk);
          rst_n = 1'b1;
          #1;
          for (int k = 0; k < tn; k++) begin
            // R1 idle, R2 fetch, then tag-specific execute steps
            chk(tr[k], (k < 3) ? ((k == 0) ? "R1" : "R2") : tag, op, k);
            @(posedge clk);
            #1;
          end
        end
    // R10 is also covered by the bound assertions over the whole sweep
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule